// File: doc/BRIEF.md
# Row-Accumulating Covariance Matrix Memory

This block keeps a 17 x 17 matrix of 56-bit signed entries in on-chip RAM and builds it up as a running sum. Upstream logic produces one row of products at a time. It hands the whole row over in one transaction, and the memory adds each of the 17 incoming values to the entry already stored at that row. Over many transactions, the contributions of all particles collect in the matrix.

A consumer reads the result one entry at a time by row and column. A clear command zeroes the whole matrix before the next pass. Each accumulate goes through a read-modify-write pipeline: the stored row is read in one cycle, and the sum is written back in the next. A forwarding path keeps results exact when accumulates or reads follow one another closely.

Top module: `cov_accum_mem`

## Requirements
- R1: While `rst` is high and after it falls, `busy` is high. The block zeroes the matrix one row per cycle, and `busy` falls after exactly 17 cycles. Every entry then reads 0.
- R2: `clr_req` sampled high while `busy` is low raises `busy` at the next edge. `busy` then stays high for exactly 17 cycles, after which every entry reads 0.
- R3: An accepted accumulate (`acc_valid` high, `acc_row` below 17) adds slice c of `acc_data` (bits c*56+55 down to c*56) to entry (`acc_row`, c) for every column c. The addition is two's complement modulo 2^56 and wraps without saturating.
- R4: Accumulates on consecutive cycles to the same row all take effect. None is lost.
- R5: A read accepted at a clock edge (`rd_req` high, `rd_row` and `rd_col` both below 17) gives a one-cycle `rd_valid` pulse two edges later. `rd_data` then holds the entry at (`rd_row`, `rd_col`). `rd_valid` is low one edge after the request.
- R6: A read issued in the cycle right after an accumulate to the same row returns the sum that includes that accumulate.
- R7: Accumulates and reads are ignored while `busy` is high, in a cycle where `clr_req` is high, and when a row or column index is 17 or more. An ignored read gives no `rd_valid` pulse. An ignored accumulate leaves every entry unchanged.
- R8: `rd_data` keeps its last value while `rd_valid` is low.
- R9: An accumulate changes only the addressed row. Entries in all other rows keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a clear |
| clr_req | input | 1 | Request to zero the whole matrix |
| acc_valid | input | 1 | Accumulate request |
| acc_row | input | 5 | Row that receives the accumulate |
| acc_data | input | 952 | 17 addends of 56 bits; column c at bits c*56 and up |
| rd_req | input | 1 | Element read request |
| rd_row | input | 5 | Row of the element to read |
| rd_col | input | 5 | Column of the element to read |
| rd_valid | output | 1 | `rd_data` holds the result of a read |
| rd_data | output | 56 | Entry returned by a read |
| busy | output | 1 | Clear in progress; requests are ignored |

## Verification
The hardest case to reach from the ports is a pending write that has not yet landed in RAM while a new access to the same row arrives. This occurs when accumulates to one row come on consecutive cycles, or when a read follows an accumulate after one cycle. The stimulus table sends a burst of back-to-back accumulates that repeats row 3 three times in a row. A directed test issues a read in the cycle right after an accumulate. Wrap-around is reached by adding all-ones and near-sign-bit values to entries that are already populated.

// File: rtl/cov_pkg.sv
package cov_pkg;
    localparam int DIM   = 17;
    localparam int EW    = 56;
    localparam int IDX_W = $clog2(DIM);

    typedef logic [EW-1:0]             entry_t;
    typedef logic [DIM-1:0][EW-1:0]    row_t;
    typedef logic [IDX_W-1:0]          idx_t;

    localparam idx_t DIM_IDX  = idx_t'(DIM);
    localparam idx_t LAST_IDX = idx_t'(DIM - 1);

    // accumulate stage between RAM read and write-back
    typedef struct packed {
        logic vld;
        idx_t row;
        row_t add;
    } acc_stage_t;

    // element read stage between RAM read and output register
    typedef struct packed {
        logic   vld;
        idx_t   col;
        logic   fwd;
        entry_t fwd_val;
    } rd_stage_t;

    function automatic entry_t wrap_add(entry_t a, entry_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/cov_col_bank.sv
module cov_col_bank #(
    parameter int DEPTH = 17,
    parameter int WIDTH = 56,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    ra_addr,
    output logic [WIDTH-1:0] ra_q,
    input  logic [AW-1:0]    rb_addr,
    output logic [WIDTH-1:0] rb_q
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        ra_q <= mem[ra_addr];
        rb_q <= mem[rb_addr];
    end
endmodule

// File: rtl/cov_clear_seq.sv
module cov_clear_seq
    import cov_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic wr_en,
    output idx_t wr_row
);
    idx_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_IDX) busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    assign wr_en  = busy;
    assign wr_row = cnt;
endmodule

// File: rtl/cov_row_adder.sv
module cov_row_adder
    import cov_pkg::*;
(
    input  row_t mem_row,
    input  logic fwd,
    input  row_t fwd_row,
    input  row_t add_row,
    output row_t sum_row
);
    for (genvar c = 0; c < DIM; c++) begin : g_col
        entry_t base;
        assign base       = fwd ? fwd_row[c] : mem_row[c];
        assign sum_row[c] = wrap_add(base, add_row[c]);
    end
endmodule

// File: rtl/cov_accum_mem.sv
module cov_accum_mem
    import cov_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_req,
    input  logic                acc_valid,
    input  logic [IDX_W-1:0]    acc_row,
    input  logic [DIM*EW-1:0]   acc_data,
    input  logic                rd_req,
    input  logic [IDX_W-1:0]    rd_row,
    input  logic [IDX_W-1:0]    rd_col,
    output logic                rd_valid,
    output logic [EW-1:0]       rd_data,
    output logic                busy
);
    logic       acc_go, rd_go;
    logic       clr_wr;
    idx_t       clr_row;
    acc_stage_t p1;
    logic       fwd_r;
    row_t       fwd_row_r;
    row_t       mem_row, bank_rd, sum_row;
    rd_stage_t  rs1;

    assign acc_go = acc_valid && !busy && !clr_req && (acc_row < DIM_IDX);
    assign rd_go  = rd_req && !busy && !clr_req &&
                    (rd_row < DIM_IDX) && (rd_col < DIM_IDX);

    cov_clear_seq clr_i (
        .clk    (clk),
        .rst    (rst),
        .start  (clr_req),
        .busy   (busy),
        .wr_en  (clr_wr),
        .wr_row (clr_row)
    );

    for (genvar c = 0; c < DIM; c++) begin : g_bank
        logic   we;
        idx_t   waddr;
        entry_t wdata;
        assign we    = clr_wr || p1.vld;
        assign waddr = clr_wr ? clr_row : p1.row;
        assign wdata = clr_wr ? '0 : sum_row[c];

        cov_col_bank #(.DEPTH(DIM), .WIDTH(EW), .AW(IDX_W)) bank_i (
            .clk     (clk),
            .we      (we),
            .waddr   (waddr),
            .wdata   (wdata),
            .ra_addr (acc_row),
            .ra_q    (mem_row[c]),
            .rb_addr (rd_row),
            .rb_q    (bank_rd[c])
        );
    end

    cov_row_adder add_i (
        .mem_row (mem_row),
        .fwd     (fwd_r),
        .fwd_row (fwd_row_r),
        .add_row (p1.add),
        .sum_row (sum_row)
    );

    // accumulate pipeline: capture, then write back next edge
    always_ff @(posedge clk) begin
        if (rst) begin
            p1        <= '0;
            fwd_r     <= 1'b0;
            fwd_row_r <= '0;
        end else begin
            p1.vld    <= acc_go;
            p1.row    <= acc_row;
            p1.add    <= row_t'(acc_data);
            fwd_r     <= acc_go && p1.vld && (p1.row == acc_row);
            fwd_row_r <= sum_row;
        end
    end

    // element read pipeline: RAM/forward capture, then output register
    always_ff @(posedge clk) begin
        if (rst) begin
            rs1      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rs1.vld     <= rd_go;
            rs1.col     <= rd_col;
            rs1.fwd     <= p1.vld && (p1.row == rd_row);
            rs1.fwd_val <= sum_row[rd_col];
            rd_valid    <= rs1.vld;
            if (rs1.vld)
                rd_data <= rs1.fwd ? rs1.fwd_val : bank_rd[rs1.col];
        end
    end
endmodule

// File: rtl/cov_accum_mem_chk.sv
module cov_accum_mem_chk
    import cov_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_req,
    input logic             rd_req,
    input logic [IDX_W-1:0] rd_row,
    input logic [IDX_W-1:0] rd_col,
    input logic             rd_valid,
    input logic [EW-1:0]    rd_data,
    input logic             busy
);
    logic [IDX_W:0] bcnt;
    logic           rd_ok;

    assign rd_ok = rd_req && !busy && !clr_req &&
                   (rd_row < DIM_IDX) && (rd_col < DIM_IDX);

    always_ff @(posedge clk) begin
        if (rst)       bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    // R1
    reset_busy_chk: assert property (@(posedge clk) rst |=> busy);

    // R2
    clr_start_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !busy) |=> busy);

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bcnt < (IDX_W+1)'(DIM)));

    // R5
    rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_ok, 2) |-> rd_valid);

    // R7
    rd_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_ok, 2));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(rd_data));
endmodule

bind cov_accum_mem cov_accum_mem_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .clr_req  (clr_req),
    .rd_req   (rd_req),
    .rd_row   (rd_row),
    .rd_col   (rd_col),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .busy     (busy)
);

// File: tb/cov_accum_mem_tb_top.sv
`timescale 1ns/1ps
module cov_accum_mem_tb_top;
    import cov_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr_req = 1'b0;
    logic              acc_valid = 1'b0;
    logic [IDX_W-1:0]  acc_row = '0;
    logic [DIM*EW-1:0] acc_data = '0;
    logic              rd_req = 1'b0;
    logic [IDX_W-1:0]  rd_row = '0;
    logic [IDX_W-1:0]  rd_col = '0;
    logic              rd_valid;
    logic [EW-1:0]     rd_data;
    logic              busy;

    int total = 0;
    int bad   = 0;
    entry_t model [DIM][DIM];

    always #2.5 clk = ~clk;

    cov_accum_mem dut_i (.*);

    localparam int NV = 10;
    localparam int     VROW  [NV] = '{3, 3, 3, 0, 16, 7, 3, 16, 0, 7};
    localparam entry_t VBASE [NV] = '{
        56'h00_0000_0000_0001, 56'hFF_FFFF_FFFF_FFFF, 56'h12_3456_789A_BCDE,
        56'h7F_FFFF_FFFF_FFF0, 56'h80_0000_0000_0000, 56'h00_0000_0001_0000,
        56'hFF_FFFF_FFFF_FF00, 56'h80_0000_0000_0001, 56'h00_00AB_CDEF_0000,
        56'hC0_0000_0000_0000};

    function automatic entry_t pat(entry_t base, int c);
        return base + entry_t'(c) * 56'h00_0100_0000_0101;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) model[r][c] = '0;
    endtask

    // drives acc inputs at current negedge; caller advances time
    task automatic set_acc(int row, entry_t base, bit apply);
        acc_valid = 1'b1;
        acc_row   = IDX_W'(row);
        for (int c = 0; c < DIM; c++) begin
            acc_data[c*EW +: EW] = pat(base, c);
            if (apply) model[row][c] = model[row][c] + pat(base, c);
        end
    endtask

    task automatic read_chk(int r, int c, string req);
        @(negedge clk);
        rd_req = 1'b1; rd_row = IDX_W'(r); rd_col = IDX_W'(c);
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid == 1'b0, {req, " latency-early"}, 64'(rd_valid), 64'd0);
        @(negedge clk);
        chk(rd_valid == 1'b1, {req, " valid"}, 64'(rd_valid), 64'd1);
        chk(rd_data == model[r][c], req, 64'(rd_data), 64'(model[r][c]));
    endtask

    task automatic scan_all(string req);
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) read_chk(r, c, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        entry_t held;
        model_clear();

        // R1: reset state and clear length
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1 busy in reset", 64'(busy), 64'd1);
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", 64'(rd_valid), 64'd0);
        rst = 1'b0;
        n = 0;
        while (busy) begin @(negedge clk); n++; end
        chk(n == DIM, "R1 busy length", 64'(n), 64'(DIM));
        scan_all("R1 zero after reset");

        // R3 R4 R9: table of back-to-back accumulates, then full scan
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            set_acc(VROW[i], VBASE[i], 1'b1);
            @(negedge clk);
        end
        acc_valid = 1'b0;
        scan_all("R3 R4 R9 table");

        // R6: read right after accumulate to same row
        @(negedge clk);
        set_acc(5, 56'h00_0000_0000_0777, 1'b1);
        @(negedge clk);
        acc_valid = 1'b0;
        rd_req = 1'b1; rd_row = 5; rd_col = 3;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b1, "R6 valid", 64'(rd_valid), 64'd1);
        chk(rd_data == model[5][3], "R6 forwarded", 64'(rd_data), 64'(model[5][3]));

        // R8: output holds while idle
        held = rd_data;
        repeat (4) begin
            @(negedge clk);
            chk(rd_data == held, "R8 hold", 64'(rd_data), 64'(held));
        end

        // R7: out-of-range indices ignored
        set_acc(17, 56'h00_0000_0000_5555, 1'b0);
        @(negedge clk);
        acc_valid = 1'b0;
        rd_req = 1'b1; rd_row = 20; rd_col = 2;
        @(negedge clk);
        rd_req = 1'b1; rd_row = 2; rd_col = 17;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid == 1'b0, "R7 bad row read", 64'(rd_valid), 64'd0);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 bad col read", 64'(rd_valid), 64'd0);
        scan_all("R7 bad row acc ignored");

        // R2 R7: clear with requests in clr cycle and during busy
        @(negedge clk);
        clr_req = 1'b1;
        set_acc(0, 56'h00_0000_0000_0042, 1'b0);
        rd_req = 1'b1; rd_row = 0; rd_col = 0;
        @(negedge clk);
        clr_req = 1'b0;
        chk(busy == 1'b1, "R2 busy after clr", 64'(busy), 64'd1);
        n = 0;
        while (busy) begin
            chk(rd_valid == 1'b0, "R7 read during busy", 64'(rd_valid), 64'd0);
            @(negedge clk);
            n++;
        end
        acc_valid = 1'b0;
        rd_req = 1'b0;
        chk(n == DIM, "R2 busy length", 64'(n), 64'(DIM));
        model_clear();
        scan_all("R2 R7 zero after clear");

        // R3 R4: wrap-around with back-to-back same row
        @(negedge clk);
        set_acc(9, 56'hFF_FFFF_FFFF_FFFF, 1'b1);
        @(negedge clk);
        set_acc(9, 56'h00_0000_0000_0002, 1'b1);
        @(negedge clk);
        acc_valid = 1'b0;
        read_chk(9, 0, "R3 wrap col0");
        chk(model[9][0] == 56'd1, "R3 wrap expected", 64'(model[9][0]), 64'd1);
        read_chk(9, 16, "R4 wrap col16");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule